// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial input line. The line is first brought into the local clock domain by a two-stage synchroniser. All decisions are then taken on clock cycles where an external oversample tick is high. The tick runs at 8 or 16 times the baud rate, and a mode input selects which. The baud-rate generator that produces the tick is outside this block.

While idle, the receiver counts consecutive low samples. Only a low run lasting half a bit period is accepted as a start bit; a shorter dip is discarded. From that point every later bit is taken from one sample exactly one bit period after the previous one, which places each sample at mid-bit.

Character length (5 to 9 bits), bit order and parity mode are set by configuration inputs. These inputs must be held steady while a character is being received. Only the first stop bit is examined. Right after it is sampled the receiver looks for the next start bit, so it stays in step even if the far end sends more stop bits. Each finished character produces a one-cycle valid strobe together with the data, a parity error flag and a framing error flag. These outputs keep their values until the next character completes.

Top module: `serial_os_rx`

## Requirements
- R1: While rst_n is low and after its release, rx_valid, rx_data, rx_par_err and rx_frm_err are all 0 until a character completes.
- R2: A start bit is accepted only after the synchronised line reads low on 4 consecutive tick samples (cfg_os16=0) or 8 consecutive tick samples (cfg_os16=1). A low run one sample shorter than that is discarded and produces no character.
- R3: After the start bit is accepted, each further bit (data, parity, stop) is taken from the single tick sample that lies 8 ticks (cfg_os16=0) or 16 ticks (cfg_os16=1) after the previous sample.
- R4: The character length is 5 + cfg_len when cfg_nine=0 (cfg_len 0..3 gives 5..8 bits) and 9 when cfg_nine=1. rx_data bits above the character length read 0.
- R5: With cfg_msb_first=0 the first received data bit lands in rx_data[0]. With cfg_msb_first=1 it lands in rx_data[N-1], where N is the character length.
- R6: cfg_par selects the parity mode: 0 none (no parity bit expected), 1 even, 2 odd, 3 parity bit forced 0, 4 parity bit forced 1, 5..7 treated as none. rx_par_err is 1 exactly when a parity bit is expected and differs from the required value. In mode none it is always 0.
- R7: Only one stop bit is checked. rx_frm_err is 1 when that sample is low. Start search resumes on the very next tick, so back-to-back frames with a single stop bit are received, and extra stop bits from the sender have no effect.
- R8: rx_valid is high for exactly one clock cycle per character. rx_data, rx_par_err and rx_frm_err change only in that cycle and otherwise hold their values.
- R9: rx_valid rises only in the clock cycle that follows a cycle with os_tick high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversample enable, 8x or 16x the baud rate |
| rxd | input | 1 | Asynchronous serial line, idle high |
| cfg_os16 | input | 1 | 1: 16 samples per bit, 0: 8 samples per bit |
| cfg_len | input | 2 | Character length minus 5 when cfg_nine is 0 |
| cfg_nine | input | 1 | 1: 9-bit characters |
| cfg_msb_first | input | 1 | 1: most significant bit sent first |
| cfg_par | input | 3 | Parity mode (see R6) |
| rx_data | output | 9 | Last received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| rx_par_err | output | 1 | Parity mismatch on the last character |
| rx_frm_err | output | 1 | Stop bit sampled low on the last character |

## Verification
On every cycle the assertions check the shape of the output handshake. The valid strobe lasts a single cycle and always follows a tick cycle. The data and flags move only with the strobe. A 9-bit field never appears in shorter modes, and the parity flag stays low when no parity is expected. The bench scenarios cover what the assertions cannot see. These are the half-bit start threshold with a run exactly one sample short, the mid-bit sample position in both oversampling modes, and bit order and length assembly. They also cover each parity rule with and without an injected error, a stop bit that is low only across its sampling point, and zero-gap frames after a single stop bit.

// File: rtl/rxo_pkg.sv
// Package: shared constants and types for the oversampling receiver.
// Assumes: characters are at most 9 bits; tick counters span one bit period.
package rxo_pkg;
    localparam int DATA_MAX = 9;
    localparam int CNT_W    = 5;
    localparam int BIT_W    = 4;

    typedef enum logic [2:0] {
        PM_NONE = 3'd0,
        PM_EVEN = 3'd1,
        PM_ODD  = 3'd2,
        PM_ZERO = 3'd3,
        PM_ONE  = 3'd4
    } par_mode_e;

    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rxo_sync.sv
// Module: multi-stage synchroniser bringing an asynchronous level into clk.
// Assumes: the input is idle-high, so every stage resets to 1.
module rxo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/rxo_unpack.sv
// Module: turns the raw shift register into a right-aligned character.
// Assumes: LSB-first bits enter at the top of raw and move down; MSB-first
// bits enter at the bottom and move up; raw starts at zero for each frame.
module rxo_unpack #(
    parameter int DW = 9
) (
    input  logic [DW-1:0]        raw,
    input  logic [3:0]           nbits,
    input  logic                 msb_first,
    output logic [DW-1:0]        data
);
    localparam logic [3:0] DW4 = 4'(DW);
    logic [3:0] gap;

    // Right-align LSB-first data or mask MSB-first data to the length.
    always_comb begin
        gap = DW4 - nbits;
        if (msb_first) data = raw & ({DW{1'b1}} >> gap);
        else           data = raw >> gap;
    end
endmodule

// File: rtl/rxo_parchk.sv
// Module: compares the received parity bit against the selected rule.
// Assumes: bits above the character length in data are zero.
module rxo_parchk
    import rxo_pkg::*;
#(
    parameter int DW = 9
) (
    input  logic [DW-1:0] data,
    input  logic          par_bit,
    input  logic [2:0]    mode,
    output logic          err
);
    logic want;
    logic used;

    // Derive the required parity bit and whether parity is in use.
    always_comb begin
        used = 1'b1;
        case (mode)
            PM_EVEN: want = ^data;
            PM_ODD:  want = ~^data;
            PM_ZERO: want = 1'b0;
            PM_ONE:  want = 1'b1;
            default: begin want = 1'b0; used = 1'b0; end
        endcase
        err = used && (par_bit != want);
    end
endmodule

// File: rtl/serial_os_rx.sv
// Module: oversampling asynchronous serial receiver (top).
// Detects start on a half-bit low run, samples each following bit one bit
// period later, checks parity and one stop bit, then strobes the character.
// Assumes: configuration is stable while a frame is in progress; os_tick is
// a single-cycle enable in the clk domain.
module serial_os_rx
    import rxo_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic                cfg_os16,
    input  logic [1:0]          cfg_len,
    input  logic                cfg_nine,
    input  logic                cfg_msb_first,
    input  logic [2:0]          cfg_par,
    output logic [DATA_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                rx_par_err,
    output logic                rx_frm_err
);
    localparam logic [CNT_W-1:0] HALF_X8  = CNT_W'(3);
    localparam logic [CNT_W-1:0] HALF_X16 = CNT_W'(7);
    localparam logic [CNT_W-1:0] FULL_X8  = CNT_W'(7);
    localparam logic [CNT_W-1:0] FULL_X16 = CNT_W'(15);

    logic                rxs;
    rx_state_e           state;
    logic [CNT_W-1:0]    tcnt;
    logic [BIT_W-1:0]    bcnt;
    logic [DATA_MAX-1:0] shreg;
    logic                par_bit;
    logic [3:0]          nbits;
    logic                par_on;
    logic [CNT_W-1:0]    half_last;
    logic [CNT_W-1:0]    full_last;
    logic                mid_hit;
    logic [DATA_MAX-1:0] data_w;
    logic                perr_w;

    rxo_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rxd),
        .d_sync  (rxs)
    );

    rxo_unpack #(.DW(DATA_MAX)) u_unpack (
        .raw       (shreg),
        .nbits     (nbits),
        .msb_first (cfg_msb_first),
        .data      (data_w)
    );

    rxo_parchk #(.DW(DATA_MAX)) u_par (
        .data    (data_w),
        .par_bit (par_bit),
        .mode    (cfg_par),
        .err     (perr_w)
    );

    // Decode frame geometry from the configuration inputs.
    always_comb begin
        nbits     = cfg_nine ? 4'd9 : (4'd5 + {2'b00, cfg_len});
        par_on    = (cfg_par >= 3'd1) && (cfg_par <= 3'd4);
        half_last = cfg_os16 ? HALF_X16 : HALF_X8;
        full_last = cfg_os16 ? FULL_X16 : FULL_X8;
        mid_hit   = (tcnt == full_last);
    end

    // Frame state machine, advanced only on oversample ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_HUNT;
            tcnt       <= '0;
            bcnt       <= '0;
            shreg      <= '0;
            par_bit    <= 1'b0;
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_par_err <= 1'b0;
            rx_frm_err <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (os_tick) begin
                case (state)
                    ST_HUNT: begin
                        if (rxs) begin
                            tcnt <= '0;
                        end else if (tcnt == half_last) begin
                            state <= ST_DATA;
                            tcnt  <= '0;
                            bcnt  <= '0;
                            shreg <= '0;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_DATA: begin
                        if (mid_hit) begin
                            tcnt  <= '0;
                            bcnt  <= bcnt + 1'b1;
                            shreg <= cfg_msb_first ? {shreg[DATA_MAX-2:0], rxs}
                                                   : {rxs, shreg[DATA_MAX-1:1]};
                            if (bcnt == nbits - 4'd1)
                                state <= par_on ? ST_PAR : ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    ST_PAR: begin
                        if (mid_hit) begin
                            tcnt    <= '0;
                            par_bit <= rxs;
                            state   <= ST_STOP;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: begin
                        if (mid_hit) begin
                            state      <= ST_HUNT;
                            tcnt       <= '0;
                            rx_valid   <= 1'b1;
                            rx_data    <= data_w;
                            rx_par_err <= perr_w;
                            rx_frm_err <= ~rxs;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/rxo_checker.sv
// Module: protocol checks on the receiver outputs, bound to the top.
// Assumes: configuration is stable from the stop sample to the strobe.
module rxo_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       os_tick,
    input logic       cfg_nine,
    input logic [2:0] cfg_par,
    input logic [8:0] rx_data,
    input logic       rx_valid,
    input logic       rx_par_err,
    input logic       rx_frm_err
);
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable({rx_data, rx_par_err, rx_frm_err}));

    a_r9_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(os_tick));

    a_r4_no_ninth_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !$past(cfg_nine)) |-> !rx_data[8]);

    a_r6_none_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && $past(cfg_par) == 3'd0) |-> !rx_par_err);
endmodule

bind serial_os_rx rxo_checker u_chk (.*);

// File: tb/sim_serial_os_rx.sv
module sim_serial_os_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       cfg_os16 = 1'b0;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_nine = 1'b0;
    logic       cfg_msb_first = 1'b0;
    logic [2:0] cfg_par = 3'd0;
    logic [8:0] rx_data;
    logic       rx_valid;
    logic       rx_par_err;
    logic       rx_frm_err;

    int checks = 0;
    int fails  = 0;
    int valids = 0;
    int wr = 0;
    int rd = 0;
    logic [1:0] div = 2'd0;
    bit done = 1'b0;
    logic [8:0] exp_d  [0:127];
    logic       exp_pe [0:127];
    logic       exp_fe [0:127];
    string      exp_tag[0:127];

    always #4 clk = ~clk;

    serial_os_rx u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .cfg_os16(cfg_os16), .cfg_len(cfg_len), .cfg_nine(cfg_nine),
        .cfg_msb_first(cfg_msb_first), .cfg_par(cfg_par),
        .rx_data(rx_data), .rx_valid(rx_valid),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err)
    );

    // Tick every third clock, changed away from the active edge.
    always @(negedge clk) begin
        div     <= (div == 2'd2) ? 2'd0 : div + 2'd1;
        os_tick <= (div == 2'd2);
    end

    function automatic int clen(input logic nine, input logic [1:0] len);
        return nine ? 9 : 5 + int'(len);
    endfunction

    function automatic logic want_par(input logic [8:0] d, input logic [2:0] m);
        case (m)
            3'd1: return ^d;
            3'd2: return ~^d;
            3'd4: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit par_used(input logic [2:0] m);
        return (m >= 3'd1) && (m <= 3'd4);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Compare every strobe with the oldest expected character.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            valids++;
            if (rd == wr) begin
                check(1'b0, "R2 unexpected character", 32'(rx_data), 32'h0);
            end else begin
                check(rx_data == exp_d[rd], {exp_tag[rd], " data"},
                      32'(rx_data), 32'(exp_d[rd]));
                check(rx_par_err == exp_pe[rd], "R6 parity flag",
                      32'(rx_par_err), 32'(exp_pe[rd]));
                check(rx_frm_err == exp_fe[rd], "R7 framing flag",
                      32'(rx_frm_err), 32'(exp_fe[rd]));
                rd = (rd + 1) % 128;
            end
        end
    end

    // Return just after the next clock edge that carried a tick.
    task automatic wait_tick();
        @(negedge clk);
        while (os_tick !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        for (int i = 0; i < n; i++) wait_tick();
    endtask

    // Send one frame using the current configuration and queue its result.
    task automatic send(input logic [8:0] raw, input bit bad_par,
                        input bit low_stop, input int nstop, input string tag);
        int          n   = clen(cfg_nine, cfg_len);
        int          os  = cfg_os16 ? 16 : 8;
        logic [8:0]  d   = raw & ((9'h1 << n) - 9'h1);
        logic        p   = want_par(d, cfg_par) ^ bad_par;
        exp_d[wr]   = d;
        exp_pe[wr]  = bad_par && par_used(cfg_par);
        exp_fe[wr]  = low_stop;
        exp_tag[wr] = tag;
        wr = (wr + 1) % 128;
        hold(1'b0, os);
        for (int i = 0; i < n; i++)
            hold(cfg_msb_first ? d[n-1-i] : d[i], os);
        if (par_used(cfg_par)) hold(p, os);
        if (low_stop) begin
            hold(1'b0, os / 2 + 1);
            hold(1'b1, os / 2 - 1);
        end else begin
            hold(1'b1, os);
        end
        for (int i = 1; i < nstop; i++) hold(1'b1, os);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        check(rx_valid == 0 && rx_data == 0 && !rx_par_err && !rx_frm_err,
              "R1 in reset", 32'({rx_valid, rx_data, rx_par_err, rx_frm_err}), 32'h0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        check(rx_valid == 0 && rx_data == 0 && !rx_par_err && !rx_frm_err,
              "R1 after reset", 32'({rx_valid, rx_data, rx_par_err, rx_frm_err}), 32'h0);

        // R3 / R5: directed 8-bit frames in both modes and both orders.
        cfg_os16 = 0; cfg_len = 3; cfg_msb_first = 0; cfg_par = 0;
        send(9'h0A5, 0, 0, 1, "R3 x8 lsb");
        cfg_msb_first = 1;
        send(9'h0C1, 0, 0, 1, "R5 x8 msb");
        cfg_os16 = 1;
        send(9'h03C, 0, 0, 1, "R3 x16 msb");
        cfg_msb_first = 0;
        send(9'h081, 0, 0, 1, "R5 x16 lsb");
        hold(1'b1, 4);

        // R2: a low run one sample short of half a bit must be rejected.
        for (int m = 0; m < 2; m++) begin
            int v0;
            logic [8:0] d0;
            cfg_os16 = m[0];
            v0 = valids;
            d0 = rx_data;
            hold(1'b0, cfg_os16 ? 7 : 3);
            hold(1'b1, 40);
            check(valids == v0 && rx_data == d0, "R2 short low rejected",
                  32'(valids), 32'(v0));
            send(9'h155, 0, 0, 1, "R2 frame after glitch");
        end

        // R4: every length; the 9-bit mode with a top bit set.
        cfg_os16 = 0;
        for (int l = 0; l < 4; l++) begin
            cfg_len = 2'(l);
            send(9'h1FF, 0, 0, 1, "R4 length");
        end
        cfg_nine = 1; cfg_msb_first = 1;
        send(9'h1A3, 0, 0, 1, "R4 nine bit");
        cfg_nine = 0; cfg_len = 3; cfg_msb_first = 0;

        // R6: each parity rule, good and corrupted.
        for (int pm = 1; pm <= 4; pm++) begin
            cfg_par = 3'(pm);
            send(9'h06B, 0, 0, 1, "R6 parity good");
            send(9'h06B, 1, 0, 1, "R6 parity bad");
        end
        cfg_par = 3'd6;
        send(9'h011, 0, 0, 1, "R6 reserved mode as none");

        // R7: low stop sample, then zero-gap frames and two stop bits.
        cfg_par = 0;
        send(9'h05A, 0, 1, 1, "R7 framing");
        hold(1'b1, 6);
        cfg_os16 = 1;
        send(9'h033, 0, 1, 1, "R7 framing x16");
        send(9'h0F0, 0, 0, 1, "R7 back to back a");
        send(9'h00F, 0, 0, 1, "R7 back to back b");
        send(9'h099, 0, 0, 2, "R7 two stop bits");
        send(9'h066, 0, 0, 1, "R7 after two stop");

        // Random frames with a fixed seed.
        void'($urandom(32'h5EED));
        for (int k = 0; k < 50; k++) begin
            cfg_os16      = 1'($urandom);
            cfg_len       = 2'($urandom);
            cfg_nine      = ($urandom % 5) == 0;
            cfg_msb_first = 1'($urandom);
            cfg_par       = 3'($urandom % 6);
            send(9'($urandom), ($urandom % 4) == 0, ($urandom % 6) == 0,
                 1 + int'($urandom % 2), "R3 random frame");
            hold(1'b1, 3 + int'($urandom % 5));
        end

        hold(1'b1, 40);
        check(rd == wr, "R8 all characters strobed", 32'(rd), 32'(wr));
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", rd, wr);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule